// File: doc/BRIEF.md
# ADC Power-Mode Sequencing Controller

This block is the power-management sequencer for a sampling converter. Software selects one of four power policies through a 2-bit mode field, which a single-cycle write strobe loads. The controller watches a conversion-start level and a conversion-complete pulse. From these it drives two power-domain enables (converter core and reference), the track/hold state, a power-up-complete flag and a sticky flag that reports a conversion launched too early.

The two automatic policies power down after every conversion. They wake on the next rising edge of conversion-start. The full-shutdown policy powers down as soon as the write that selects it completes, and it stays asleep until software writes normal mode. Every wake-up starts a down-counter, and the ready flag stays low until the counter reaches zero. The counter is loaded with one of three cycle counts, chosen by the policy and by the reference-source input.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset the mode is normal (code 00), both enables are high, track/hold is in hold (track=0), ready is high and the invalid flag is low.
- R2: While powered, a rising edge on conv_start puts the track/hold in track (track=1) one clock later, and a falling edge returns it to hold (track=0) one clock later. This includes the first rising edge after reset.
- R3: In normal mode (code 00), a conversion-complete pulse leaves both core_en and ref_en high, and so does a mode write of code 01 or 10.
- R4: In auto-shutdown (code 01), a conv_done pulse while ready drops core_en, ref_en, track and ready one clock later.
- R5: In auto-standby (code 10), a conv_done pulse while ready drops core_en, track and ready one clock later, and ref_en stays high.
- R6: When the block is asleep and not in full shutdown, a conv_start rising edge raises both enables and track and clears ready one clock later. In auto-shutdown, ready returns exactly LONG_WAIT clocks after that edge, whatever the ref_int value.
- R7: An auto-standby wake keeps ready low for exactly STBY_EXT_WAIT clocks when ref_int=0 and for exactly STBY_INT_WAIT clocks when ref_int=1.
- R8: Writing code 11 drops core_en, ref_en, track and ready one clock later, and conv_start edges then do not wake the block.
- R9: From full shutdown, writing code 00 raises both enables and track one clock later, and ready returns exactly LONG_WAIT clocks after the write.
- R10: The mode setting survives sleep. After an auto-shutdown wake, the next conv_done while ready powers the block down again.
- R11: A conv_start falling edge while ready is low sets err_invalid one clock later. The flag stays set until the next register write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Single-cycle mode register write strobe |
| wr_mode | input | 2 | Mode code written on wr_stb (00 normal, 01 auto-shutdown, 10 auto-standby, 11 full shutdown) |
| ref_int | input | 1 | 1 = internal reference selected, 0 = external |
| conv_start | input | 1 | Conversion-start level |
| conv_done | input | 1 | Single-cycle conversion-complete pulse |
| core_en | output | 1 | Converter core power enable |
| ref_en | output | 1 | Reference and buffer power enable |
| track | output | 1 | 1 = track, 0 = hold |
| ready | output | 1 | Power-up complete |
| err_invalid | output | 1 | Sticky early-conversion flag |

## Verification
The assertions assume that conv_done arrives as a single-cycle pulse and that a register write never lands in the same cycle as a conv_start edge. The assertions that track a wake-up also assume that each wait parameter is at least one cycle. The stimulus pulses wr_stb and conv_done for exactly one clock and changes conv_start only in cycles with no write. It also issues conv_done only once ready is high, so every sleep transition is deliberate.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;
  typedef enum logic [1:0] {
    PM_NORMAL  = 2'b00,
    PM_AUTO_SD = 2'b01,
    PM_AUTO_SB = 2'b10,
    PM_FULL_SD = 2'b11
  } pm_mode_e;

  typedef enum logic [1:0] {
    PS_ACTIVE  = 2'b00,
    PS_STANDBY = 2'b01,
    PS_OFF     = 2'b10
  } pwr_state_e;
endpackage

// File: rtl/adc_pwr_edge.sv
module adc_pwr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= din;
  end

  assign rise = din & ~prev_q;
  assign fall = ~din & prev_q;
endmodule

// File: rtl/adc_pwr_timer.sv
module adc_pwr_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  // R6 / R7: a running wait drops by exactly one per clock
  a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/adc_pwr_fsm.sv
module adc_pwr_fsm
  import adc_pwr_pkg::*;
#(
  parameter int CW            = 8,
  parameter int LONG_WAIT     = 40,
  parameter int STBY_EXT_WAIT = 6,
  parameter int STBY_INT_WAIT = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  pm_mode_e      wr_mode,
  input  logic          ref_int,
  input  logic          rise,
  input  logic          fall,
  input  logic          conv_done,
  input  logic          busy,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          core_en,
  output logic          ref_en,
  output logic          track,
  output logic          ready,
  output logic          err_invalid
);
  localparam logic [CW-1:0] LONG_C = CW'(LONG_WAIT);
  localparam logic [CW-1:0] SBE_C  = CW'(STBY_EXT_WAIT);
  localparam logic [CW-1:0] SBI_C  = CW'(STBY_INT_WAIT);

  pm_mode_e   mode_q, mode_d;
  pwr_state_e st_q, st_d;
  logic       trk_q, trk_d;
  logic       err_q, err_d;

  assign ready = (st_q == PS_ACTIVE) && !busy;

  always_comb begin
    mode_d   = mode_q;
    st_d     = st_q;
    trk_d    = trk_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (wr_stb) begin
      mode_d = wr_mode;
      if (wr_mode == PM_FULL_SD) begin
        st_d     = PS_OFF;
        trk_d    = 1'b0;
        tmr_load = 1'b1;
      end else if (mode_q == PM_FULL_SD && wr_mode == PM_NORMAL) begin
        st_d     = PS_ACTIVE;
        trk_d    = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = LONG_C;
      end
    end else if (st_q == PS_ACTIVE) begin
      if (rise)      trk_d = 1'b1;
      else if (fall) trk_d = 1'b0;
      if (conv_done && ready) begin
        case (mode_q)
          PM_AUTO_SD: begin st_d = PS_OFF;     trk_d = 1'b0; end
          PM_AUTO_SB: begin st_d = PS_STANDBY; trk_d = 1'b0; end
          default:    ;
        endcase
      end
    end else if (rise && mode_q != PM_FULL_SD) begin
      st_d     = PS_ACTIVE;
      trk_d    = 1'b1;
      tmr_load = 1'b1;
      if (mode_q == PM_AUTO_SB) tmr_val = ref_int ? SBI_C : SBE_C;
      else                      tmr_val = LONG_C;
    end
    err_d = (wr_stb ? 1'b0 : err_q) | (fall & ~ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_NORMAL;
      st_q   <= PS_ACTIVE;
      trk_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      st_q   <= st_d;
      trk_q  <= trk_d;
      err_q  <= err_d;
    end
  end

  assign core_en     = (st_q == PS_ACTIVE);
  assign ref_en      = (st_q != PS_OFF);
  assign track       = trk_q;
  assign err_invalid = err_q;

  // R3: normal mode never loses power without a write
  a_r3_normal_keeps_power: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_NORMAL && core_en && !wr_stb) |=> (core_en && ref_en));
  // R4: auto-shutdown sleeps fully after a conversion
  a_r4_sd_sleeps: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_AUTO_SD && ready && conv_done && !wr_stb) |=> (!core_en && !ref_en && !track));
  // R5: auto-standby keeps the reference up
  a_r5_sb_keeps_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_AUTO_SB && ready && conv_done && !wr_stb) |=> (ref_en && !core_en && !track));
  // R6: a wake edge powers up and starts the wait
  a_r6_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_en && rise && !wr_stb && mode_q != PM_FULL_SD) |=> (core_en && track && !ready));
  // R8: full shutdown stays down until a write
  a_r8_full_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_FULL_SD && !wr_stb) |=> !core_en);
  // R11: the invalid flag is sticky until a write
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_invalid && !wr_stb) |=> err_invalid);
  a_r11_wr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !fall) |=> !err_invalid);
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_pkg::*;
#(
  parameter int LONG_WAIT     = 1250000,
  parameter int STBY_EXT_WAIT = 75,
  parameter int STBY_INT_WAIT = 875
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [1:0] wr_mode,
  input  logic       ref_int,
  input  logic       conv_start,
  input  logic       conv_done,
  output logic       core_en,
  output logic       ref_en,
  output logic       track,
  output logic       ready,
  output logic       err_invalid
);
  localparam int MAXW = (LONG_WAIT > STBY_INT_WAIT)
                        ? ((LONG_WAIT > STBY_EXT_WAIT) ? LONG_WAIT : STBY_EXT_WAIT)
                        : ((STBY_INT_WAIT > STBY_EXT_WAIT) ? STBY_INT_WAIT : STBY_EXT_WAIT);
  localparam int CW = $clog2(MAXW + 1);

  logic          rise, fall, busy, tmr_load;
  logic [CW-1:0] tmr_val;

  adc_pwr_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (conv_start),
    .rise (rise),
    .fall (fall)
  );

  adc_pwr_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .busy    (busy)
  );

  adc_pwr_fsm #(
    .CW           (CW),
    .LONG_WAIT    (LONG_WAIT),
    .STBY_EXT_WAIT(STBY_EXT_WAIT),
    .STBY_INT_WAIT(STBY_INT_WAIT)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .wr_mode    (pm_mode_e'(wr_mode)),
    .ref_int    (ref_int),
    .rise       (rise),
    .fall       (fall),
    .conv_done  (conv_done),
    .busy       (busy),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .core_en    (core_en),
    .ref_en     (ref_en),
    .track      (track),
    .ready      (ready),
    .err_invalid(err_invalid)
  );
endmodule

// File: tb/sim_adc_pwr_seq.sv
module sim_adc_pwr_seq;
  localparam int LW  = 40;
  localparam int SBE = 6;
  localparam int SBI = 20;

  logic clk, rst_n, wr_stb, ref_int, conv_start, conv_done;
  logic [1:0] wr_mode;
  logic core_en, ref_en, track, ready, err_invalid;
  int checks = 0;
  int errors = 0;
  logic done_flag = 1'b0;

  adc_pwr_seq #(.LONG_WAIT(LW), .STBY_EXT_WAIT(SBE), .STBY_INT_WAIT(SBI)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_mode(wr_mode), .ref_int(ref_int),
    .conv_start(conv_start), .conv_done(conv_done), .core_en(core_en), .ref_en(ref_en),
    .track(track), .ready(ready), .err_invalid(err_invalid));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {wr, mode[1:0], conv_start, done | core, ref, track, ready, err}
  localparam logic [9:0] VEC [10] = '{
    10'b0_00_1_0_11110,
    10'b0_00_0_0_11010,
    10'b0_00_0_1_11010,
    10'b1_10_0_0_11010,
    10'b0_00_1_0_11110,
    10'b0_00_0_0_11010,
    10'b0_00_0_1_01000,
    10'b0_00_1_0_11100,
    10'b0_00_0_0_11001,
    10'b1_10_0_0_11000
  };

  function automatic string vec_tag(int i);
    case (i)
      2, 3:    return "R3";
      6:       return "R5";
      7:       return "R7";
      8, 9:    return "R11";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag, logic [4:0] e);
    chk(tag, "core_en", core_en, e[4]);
    chk(tag, "ref_en", ref_en, e[3]);
    chk(tag, "track", track, e[2]);
    chk(tag, "ready", ready, e[1]);
    chk(tag, "err_invalid", err_invalid, e[0]);
  endtask

  task automatic tick(logic w, logic [1:0] m, logic cs, logic d);
    @(negedge clk);
    wr_stb = w; wr_mode = m; conv_start = cs; conv_done = d;
    @(posedge clk); #1;
    wr_stb = 1'b0; conv_done = 1'b0;
  endtask

  task automatic measure(string tag, int w);
    chk(tag, "ready at wake", ready, 1'b0);
    repeat (w - 1) @(posedge clk);
    #1 chk(tag, "ready one before end", ready, 1'b0);
    @(posedge clk);
    #1 chk(tag, "ready at end", ready, 1'b1);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_stb = 1'b0; wr_mode = 2'b00; ref_int = 1'b0;
    conv_start = 1'b0; conv_done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk_all("R1", 5'b11010);

    for (int i = 0; i < 10; i++) begin
      tick(VEC[i][9], VEC[i][8:7], VEC[i][6], VEC[i][5]);
      chk_all(vec_tag(i), VEC[i][4:0]);
    end
    for (int k = 0; k < 100 && !ready; k++) @(posedge clk);
    #1;

    // auto-standby, internal reference
    tick(1'b0, 2'b00, 1'b1, 1'b0);
    tick(1'b0, 2'b00, 1'b0, 1'b0);
    tick(1'b0, 2'b00, 1'b0, 1'b1);
    chk_all("R5", 5'b01000);
    ref_int = 1'b1;
    tick(1'b0, 2'b00, 1'b1, 1'b0);
    chk_all("R6", 5'b11100);
    measure("R7", SBI);
    tick(1'b0, 2'b00, 1'b0, 1'b0);

    // auto-standby, external reference
    tick(1'b0, 2'b00, 1'b0, 1'b1);
    ref_int = 1'b0;
    tick(1'b0, 2'b00, 1'b1, 1'b0);
    measure("R7", SBE);
    tick(1'b0, 2'b00, 1'b0, 1'b0);

    // auto-shutdown
    tick(1'b1, 2'b01, 1'b0, 1'b0);
    tick(1'b0, 2'b00, 1'b0, 1'b1);
    chk_all("R4", 5'b00000);
    ref_int = 1'b1;
    tick(1'b0, 2'b00, 1'b1, 1'b0);
    chk_all("R6", 5'b11100);
    measure("R6", LW);
    tick(1'b0, 2'b00, 1'b0, 1'b0);
    tick(1'b0, 2'b00, 1'b0, 1'b1);
    chk_all("R10", 5'b00000);
    ref_int = 1'b0;
    tick(1'b0, 2'b00, 1'b1, 1'b0);
    measure("R6", LW);
    tick(1'b0, 2'b00, 1'b0, 1'b0);

    // full shutdown
    tick(1'b1, 2'b11, 1'b0, 1'b0);
    chk_all("R8", 5'b00000);
    tick(1'b0, 2'b00, 1'b1, 1'b0);
    chk_all("R8", 5'b00000);
    tick(1'b0, 2'b00, 1'b0, 1'b0);
    chk_all("R11", 5'b00001);
    repeat (3) @(posedge clk);
    #1 chk("R11", "err held", err_invalid, 1'b1);
    chk("R8", "core stays off", core_en, 1'b0);
    tick(1'b1, 2'b00, 1'b0, 1'b0);
    chk_all("R9", 5'b11100);
    measure("R9", LW);

    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule